// File: doc/BRIEF.md
# TMDS Video Channel Encoder

This block encodes one colour channel of a digital display link. On every pixel clock it accepts one input and produces one 10-bit line symbol, so the serial stream that follows runs at ten times the pixel rate. While video is enabled, an 8-bit pixel byte is widened to 10 bits in two stages. The first stage chains XOR or XNOR operations through the byte to reduce the number of transitions on the line. The second stage can invert the result to steer a running DC disparity toward zero.

While video is disabled (blanking), the encoder sends one of four reserved control symbols, selected by a 2-bit control input. On the blue channel the low control bit carries horizontal sync and the high bit carries vertical sync. On the red and green channels the control bits are usually held at zero.

The symbol is registered. It appears one pixel clock after its inputs, with the same latency on the data path and the control path. A serialiser downstream shifts each symbol out.

Top module: `tmds_channel_enc`

## Requirements
- R1: Each clock edge with reset low registers exactly one symbol, built from the inputs sampled at that edge. The symbol is visible on `sym_out` after that edge, on both the data path and the control path.
- R2: With `de` low, `sym_out` becomes a control token chosen by `ctrl` = {bit1, bit0}:
  - 00 gives 1101010100
  - 01 gives 0010101011
  - 10 gives 0101010100
  - 11 gives 1010101011
- R3: Bit 8 of a data symbol is 0 when the input byte has more than four ones, or exactly four ones with bit 0 equal to 0. In both cases the intermediate word was built with XNOR. Otherwise bit 8 is 1, meaning XOR was used.
- R4: This rule decides bit 9 and whether the low 8 bits are inverted. Let q be the low 8 bits of the intermediate word and D the running disparity.
  - If D is 0, or q holds exactly four ones, bit 9 is the inverse of bit 8, and q is inverted exactly when bit 8 is 0.
  - Otherwise, q is inverted and bit 9 is set when D>0 and q holds more than four ones, or when D<0 and q holds fewer than four ones.
  - In every remaining case q is sent unchanged with bit 9 clear.
- R5: After each data symbol, D changes by the symbol's count of ones minus its count of zeros, over all 10 bits.
- R6: D is cleared by every control period, so the first data symbol after blanking is coded as if D were 0.
- R7: While reset is high, `sym_out` holds the 00 control token and D is 0.
- R8: Every data symbol decodes back to its input byte. To decode, undo the bit-9 inversion. Bit 0 is then taken as is. Each later bit is the XOR of adjacent bits when bit 8 is 1, and the XNOR of adjacent bits when bit 8 is 0.
- R9: A data symbol never equals any of the four control tokens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de | input | 1 | Video data enable; low selects a control token |
| ctrl | input | 2 | Control selector; on the blue channel bit 0 is hsync and bit 1 is vsync |
| data | input | DATA_W | Pixel byte for this channel |
| sym_out | output | DATA_W+2 | Registered 10-bit line symbol |

## Verification
The hardest branch to reach is the one where the running disparity is non-zero but the intermediate word is balanced. It can only be reached after earlier symbols have pushed the disparity away from zero, and it depends on the exact order of biased and balanced bytes.

The stimulus builds disparity with runs of heavily biased bytes, such as long runs of 0x01 or 0xFE. It then feeds balanced bytes like 0x0F and 0xF0. It also sweeps all 256 byte values back to back and runs a long pseudo-random stream mixed with blanking. Blanking interrupts a biased run, and a reset arrives mid-stream.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;
  localparam int TOK_W = 10;
  localparam logic [TOK_W-1:0] CTL_TOK_00 = 10'b1101010100;
  localparam logic [TOK_W-1:0] CTL_TOK_01 = 10'b0010101011;
  localparam logic [TOK_W-1:0] CTL_TOK_10 = 10'b0101010100;
  localparam logic [TOK_W-1:0] CTL_TOK_11 = 10'b1010101011;
endpackage

// File: rtl/tmds_xmin_stage.sv
module tmds_xmin_stage #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W:0]   qm
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int HALF  = DATA_W / 2;

  logic [CNT_W-1:0]  ones;
  logic              use_xnor;
  logic [DATA_W-1:0] chain;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) ones = ones + CNT_W'(din[i]);
  end

  // Pick the chaining operation that yields fewer transitions.
  assign use_xnor = (ones > CNT_W'(HALF)) || ((ones == CNT_W'(HALF)) && !din[0]);

  always_comb begin
    chain[0] = din[0];
    for (int i = 1; i < DATA_W; i++)
      chain[i] = use_xnor ? ~(chain[i-1] ^ din[i]) : (chain[i-1] ^ din[i]);
  end

  assign qm = {~use_xnor, chain};
endmodule

// File: rtl/tmds_dc_balance.sv
module tmds_dc_balance #(
  parameter int DATA_W = 8,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              de,
  input  logic [DATA_W:0]   qm,
  output logic [DATA_W+1:0] sym
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic signed [DISP_W-1:0] TWO  = DISP_W'(2);
  localparam logic signed [DISP_W-1:0] ZERO = '0;

  logic [CNT_W-1:0]         n1, n0;
  logic signed [DISP_W-1:0] disp, disp_nxt, bal;
  logic [DATA_W-1:0]        low;
  logic                     xor_used;

  assign low      = qm[DATA_W-1:0];
  assign xor_used = qm[DATA_W];

  always_comb begin
    n1 = '0;
    for (int i = 0; i < DATA_W; i++) n1 = n1 + CNT_W'(low[i]);
  end
  assign n0  = CNT_W'(DATA_W) - n1;
  assign bal = $signed(DISP_W'(n1)) - $signed(DISP_W'(n0));

  always_comb begin
    if ((disp == ZERO) || (n1 == n0)) begin
      sym      = {~xor_used, xor_used, xor_used ? low : ~low};
      disp_nxt = xor_used ? (disp + bal) : (disp - bal);
    end else if (((disp > ZERO) && (n1 > n0)) || ((disp < ZERO) && (n0 > n1))) begin
      sym      = {1'b1, xor_used, ~low};
      disp_nxt = disp + (xor_used ? TWO : ZERO) - bal;
    end else begin
      sym      = {1'b0, xor_used, low};
      disp_nxt = disp - (xor_used ? ZERO : TWO) + bal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      disp <= '0;
    else if (!de) disp <= '0;
    else          disp <= disp_nxt;
  end

  assert_disp_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !de |=> (disp == ZERO));

  assert_disp_even_R5: assert property (@(posedge clk) disable iff (rst)
    disp[0] == 1'b0);
endmodule

// File: rtl/tmds_ctrl_token.sv
module tmds_ctrl_token
  import tmds_enc_pkg::*;
(
  input  logic [1:0]       sel,
  output logic [TOK_W-1:0] tok
);
  always_comb begin
    case (sel)
      2'b00:   tok = CTL_TOK_00;
      2'b01:   tok = CTL_TOK_01;
      2'b10:   tok = CTL_TOK_10;
      default: tok = CTL_TOK_11;
    endcase
  end
endmodule

// File: rtl/tmds_channel_enc.sv
module tmds_channel_enc
  import tmds_enc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              de,
  input  logic [1:0]        ctrl,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W+1:0] sym_out
);
  localparam int SYM_W = DATA_W + 2;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W:0]    qm;
  logic [SYM_W-1:0]   data_sym;
  logic [TOK_W-1:0]   ctl_tok;

  tmds_xmin_stage #(.DATA_W(DATA_W)) u_xmin (
    .din (data),
    .qm  (qm)
  );

  tmds_dc_balance #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_bal (
    .clk (clk),
    .rst (rst),
    .de  (de),
    .qm  (qm),
    .sym (data_sym)
  );

  tmds_ctrl_token u_tok (
    .sel (ctrl),
    .tok (ctl_tok)
  );

  always_ff @(posedge clk) begin
    if (rst)     sym_out <= SYM_W'(CTL_TOK_00);
    else if (de) sym_out <= data_sym;
    else         sym_out <= SYM_W'(ctl_tok);
  end

  function automatic logic [DATA_W-1:0] unwind(input logic [SYM_W-1:0] s);
    logic [DATA_W-1:0] d, r;
    d    = s[DATA_W+1] ? ~s[DATA_W-1:0] : s[DATA_W-1:0];
    r[0] = d[0];
    for (int i = 1; i < DATA_W; i++)
      r[i] = s[DATA_W] ? (d[i] ^ d[i-1]) : ~(d[i] ^ d[i-1]);
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] popc(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  assert_reset_token_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sym_out == SYM_W'(CTL_TOK_00)));

  assert_ctrl_path_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(de) && ($past(ctrl) == 2'b11)) |-> (sym_out == SYM_W'(CTL_TOK_11)));

  assert_roundtrip_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(de)) |-> (unwind(sym_out) == $past(data)));

  assert_choice_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(de)) |->
      (sym_out[DATA_W] == !((popc($past(data)) > CNT_W'(DATA_W/2)) ||
                            ((popc($past(data)) == CNT_W'(DATA_W/2)) && !$past(data[0])))));

  assert_no_token_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(de)) |->
      ((sym_out != SYM_W'(CTL_TOK_00)) && (sym_out != SYM_W'(CTL_TOK_01)) &&
       (sym_out != SYM_W'(CTL_TOK_10)) && (sym_out != SYM_W'(CTL_TOK_11))));
endmodule

// File: tb/tmds_channel_enc_test.sv
module tmds_channel_enc_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       de = 1'b0;
  logic [1:0] ctrl = 2'b00;
  logic [7:0] data = 8'h00;
  logic [9:0] sym_out;

  int n_checks = 0;
  int n_fails  = 0;
  int disp_m   = 0;

  logic [9:0] exp_sym  = 10'b1101010100;
  logic       exp_de   = 1'b0;
  logic [7:0] exp_data = 8'h00;
  string      exp_tag  = "R7";

  tmds_channel_enc uut (
    .clk(clk), .rst(rst), .de(de), .ctrl(ctrl), .data(data), .sym_out(sym_out)
  );

  always #10 clk = ~clk;

  function automatic int ones8(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) if (v[i]) c++;
    return c;
  endfunction

  // Behavioural reference: compute next symbol and advance model disparity.
  task automatic model(input logic de_i, input logic [1:0] c_i, input logic [7:0] d_i);
    logic [7:0] q;
    logic       xn, inv;
    int         k, n1, tot;
    if (!de_i) begin
      case (c_i)
        2'b00: exp_sym = 10'b1101010100;
        2'b01: exp_sym = 10'b0010101011;
        2'b10: exp_sym = 10'b0101010100;
        default: exp_sym = 10'b1010101011;
      endcase
      disp_m = 0;
    end else begin
      k  = ones8(d_i);
      xn = (k > 4) || (k == 4 && d_i[0] == 1'b0);
      q[0] = d_i[0];
      for (int i = 1; i < 8; i++) q[i] = xn ? ~(q[i-1] ^ d_i[i]) : (q[i-1] ^ d_i[i]);
      n1 = ones8(q);
      if (disp_m == 0 || n1 == 4) inv = xn;
      else inv = (disp_m > 0 && n1 > 4) || (disp_m < 0 && n1 < 4);
      exp_sym = {inv, ~xn, inv ? ~q : q};
      tot = 0;
      for (int i = 0; i < 10; i++) if (exp_sym[i]) tot++;
      disp_m = disp_m + tot - (10 - tot);
    end
    exp_de   = de_i;
    exp_data = d_i;
  endtask

  function automatic logic [7:0] decode(input logic [9:0] s);
    logic [7:0] d, r;
    d = s[9] ? ~s[7:0] : s[7:0];
    r[0] = d[0];
    for (int i = 1; i < 8; i++) r[i] = s[8] ? (d[i] ^ d[i-1]) : ~(d[i] ^ d[i-1]);
    return r;
  endfunction

  task automatic compare();
    n_checks++;
    if (sym_out !== exp_sym) begin
      n_fails++;
      $display("FAIL %s: sym_out=%b expected=%b", exp_tag, sym_out, exp_sym);
    end
    if (exp_de) begin
      n_checks++;
      if (decode(sym_out) !== exp_data) begin
        n_fails++;
        $display("FAIL R8: decoded=%h expected=%h", decode(sym_out), exp_data);
      end
      n_checks++;
      if (sym_out[8] !== exp_sym[8]) begin
        n_fails++;
        $display("FAIL R3: bit8=%b expected=%b", sym_out[8], exp_sym[8]);
      end
    end
  endtask

  task automatic step(input logic de_i, input logic [1:0] c_i, input logic [7:0] d_i, input string tag);
    @(negedge clk);
    compare();
    rst = 1'b0; de = de_i; ctrl = c_i; data = d_i;
    model(de_i, c_i, d_i);
    exp_tag = tag;
  endtask

  task automatic hold_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      rst = 1'b1; de = 1'b1; data = 8'hFF;
      disp_m = 0; exp_sym = 10'b1101010100; exp_de = 1'b0; exp_tag = "R7";
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    hold_reset(3);
    // R2: all four control tokens
    for (int c = 0; c < 4; c++) step(1'b0, 2'(c), 8'h00, "R2");
    // R3: the choice between XOR and XNOR chains
    step(1'b1, 2'b00, 8'h0F, "R3");
    step(1'b1, 2'b00, 8'hF0, "R3");
    step(1'b1, 2'b00, 8'h1E, "R3");
    step(1'b1, 2'b00, 8'h00, "R3");
    step(1'b1, 2'b00, 8'hFF, "R3");
    // R4/R5: build disparity, then feed balanced words
    for (int i = 0; i < 6; i++) step(1'b1, 2'b00, 8'h01, "R4");
    step(1'b1, 2'b00, 8'h0F, "R4");
    step(1'b1, 2'b00, 8'hF0, "R4");
    for (int i = 0; i < 6; i++) step(1'b1, 2'b00, 8'hFE, "R5");
    step(1'b1, 2'b00, 8'h55, "R5");
    step(1'b1, 2'b00, 8'hAA, "R5");
    step(1'b1, 2'b00, 8'h33, "R5");
    // R6: blanking in the middle of a biased run
    for (int i = 0; i < 3; i++) step(1'b1, 2'b00, 8'h03, "R6");
    step(1'b0, 2'b01, 8'h03, "R6");
    step(1'b1, 2'b00, 8'h03, "R6");
    step(1'b1, 2'b00, 8'h0F, "R6");
    // R1/R9: every byte back to back
    for (int v = 0; v < 256; v++) step(1'b1, 2'b00, 8'(v), "R1");
    step(1'b0, 2'b10, 8'h00, "R2");
    for (int v = 255; v >= 0; v--) step(1'b1, 2'b00, 8'(v), "R9");
    // Mixed pseudo-random stream with blanking
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[15:12] != 4'h0, lfsr[9:8], lfsr[7:0], "R5");
    end
    // R7: reset mid-stream
    for (int i = 0; i < 4; i++) step(1'b1, 2'b00, 8'h07, "R4");
    hold_reset(2);
    step(1'b1, 2'b00, 8'h07, "R7");
    step(1'b1, 2'b00, 8'h07, "R7");
    step(1'b0, 2'b11, 8'h00, "R2");
    step(1'b0, 2'b00, 8'h00, "R2");
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule